// File: doc/BRIEF.md
# Bus Ownership Handover Arbiter

This block manages the handover of a shared bus between the master that normally owns it and one alternate master, such as a DMA engine. Three active-low handshake lines tie the two sides together: a bus request raised by the alternate side, a bus grant returned by the owning master, and a grant acknowledge raised by the alternate side once it has actually taken the bus. The owning master cannot refuse a request. Its grant is a promise to step off the bus once the current transfer is over. The grant does not release anything by itself.

The requester half watches the bus for a quiet condition. Address strobe, data acknowledge and the acknowledge of any other bus owner must all be negated before it takes the bus. These three lines are asynchronous to the block clock, so they pass through a synchronizer of `SYNC_STAGES` flops (zero stages gives a direct path). The master half drives `master_release`. While it is high, the master's address, data and control drivers are tristated, and the read/write line has no defined value. The master takes the bus back one clock after the acknowledge goes away.

The master state machine has three states. `M_OWN` goes to `M_GRANT` when it samples a request. `M_GRANT` goes to `M_RELEASED` when it samples the acknowledge, or back to `M_OWN` when the request drops first (a withdrawn grant). `M_RELEASED` goes to `M_OWN` when it samples the acknowledge negated. The requester state machine also has three states. `Q_IDLE` goes to `Q_ASK` when it samples `dma_want`. `Q_ASK` goes back to `Q_IDLE` if `dma_want` drops, or to `Q_OWN` when the grant is present and the bus is quiet. `Q_OWN` goes to `Q_IDLE` when `dma_want` drops.

Top module: `arb_bus_handover`

## Requirements
- R1: During and right after reset, `bus_req_n`, `bus_grant_n` and `bus_gack_n` are 1, and `master_release` and `dma_owns` are 0.
- R2: `bus_req_n` goes to 0 one clock after `dma_want` is sampled high in `Q_IDLE`. It stays 0 until the requester takes the bus or `dma_want` drops.
- R3: `bus_grant_n` goes to 0 exactly one clock after `bus_req_n` is sampled 0 by the master, and never without a request that was sampled earlier.
- R4: `bus_gack_n` goes to 0 at the first clock edge where three things hold: the grant is present, and `as_n`, `dtack_n` and `ext_gack_n`, each delayed by `SYNC_STAGES` clocks, were all 1. With `SYNC_STAGES`=1 and a grant that first appears after edge 2, that edge is max(3, b+2) counted from the edge that sampled `dma_want`, where b is the longest number of edges during which one of the three lines was seen low.
- R5: One clock after `bus_gack_n` is sampled 0, `bus_grant_n` returns to 1 and `master_release` goes to 1 in the same cycle.
- R6: `master_release` stays 1 as long as `bus_gack_n` stays 0. It returns to 0 one clock after `bus_gack_n` is sampled 1.
- R7: If `bus_req_n` returns to 1 while the grant is present but before `bus_gack_n` has gone to 0, the grant is withdrawn one clock later and `master_release` stays 0.
- R8: At most one grant is outstanding: `bus_grant_n`=0 and `master_release`=1 never occur together.
- R9: On taking the bus, the requester drives `bus_req_n` back to 1 in the same cycle that `bus_gack_n` goes to 0 and `dma_owns` goes to 1. It drives `bus_gack_n` to 1 one clock after `dma_want` is sampled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dma_want | input | 1 | Alternate master wants the bus (level) |
| as_n | input | 1 | Address strobe of the bus, active low, asynchronous |
| dtack_n | input | 1 | Data transfer acknowledge of the bus, active low, asynchronous |
| ext_gack_n | input | 1 | Grant acknowledge of any other bus owner, active low, asynchronous |
| bus_req_n | output | 1 | Bus request from the requester, active low |
| bus_grant_n | output | 1 | Bus grant from the owning master, active low |
| bus_gack_n | output | 1 | Grant acknowledge from the requester, active low |
| dma_owns | output | 1 | Alternate master currently owns the bus |
| master_release | output | 1 | Owning master tristates its address, data and control drivers |

## Verification
The bench builds the block with `SYNC_STAGES`=1. This keeps the quiet-bus delay at one clock, so the edge where ownership passes can be computed in closed form. The bench sweeps every combination of 0 to 3 busy clocks on address strobe, data acknowledge and the foreign acknowledge. This covers the case where the bus is already quiet when the grant appears, the case where one line is the last to clear, and the case where several lines clear together. A separate run drops the request while a long transfer holds off the acknowledge, which exercises the withdrawn-grant path.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // States of the owning master
    typedef enum logic [1:0] {
        M_OWN      = 2'd0,
        M_GRANT    = 2'd1,
        M_RELEASED = 2'd2
    } mst_state_t;

    // States of the alternate requester
    typedef enum logic [1:0] {
        Q_IDLE = 2'd0,
        Q_ASK  = 2'd1,
        Q_OWN  = 2'd2
    } req_state_t;

    // Bit positions inside the synchronized watch vector
    localparam int unsigned W_AS   = 0;
    localparam int unsigned W_DTK  = 1;
    localparam int unsigned W_EXT  = 2;
    localparam int unsigned W_BITS = 3;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
    parameter int unsigned        STAGES = 2,
    parameter int unsigned        WIDTH  = 3,
    parameter logic [WIDTH-1:0]   IDLE   = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES == 0) begin : g_pass
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] chain;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < int'(STAGES); i++) begin
                        chain[i] <= IDLE;
                    end
                end else begin
                    chain[0] <= d;
                    for (int i = 1; i < int'(STAGES); i++) begin
                        chain[i] <= chain[i-1];
                    end
                end
            end

            assign q = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/arb_master_fsm.sv
module arb_master_fsm
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic gack_n,
    output logic grant_n,
    output logic release_o
);

    mst_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= M_OWN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            M_OWN: begin
                if (!req_n) begin
                    state_nx = M_GRANT;
                end
            end
            M_GRANT: begin
                if (!gack_n) begin
                    state_nx = M_RELEASED;
                end else if (req_n) begin
                    state_nx = M_OWN;
                end
            end
            M_RELEASED: begin
                if (gack_n) begin
                    state_nx = M_OWN;
                end
            end
            default: state_nx = M_OWN;
        endcase
    end

    always_comb begin
        grant_n   = 1'b1;
        release_o = 1'b0;
        unique case (state)
            M_OWN:      ;
            M_GRANT:    grant_n   = 1'b0;
            M_RELEASED: release_o = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/arb_requester_fsm.sv
module arb_requester_fsm
    import arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              want,
    input  logic              grant_n,
    input  logic [W_BITS-1:0] watch_q,
    output logic              req_n,
    output logic              gack_n,
    output logic              owns
);

    req_state_t state, state_nx;
    logic       quiet;

    // Every watched line is active low: quiet means all of them read 1
    assign quiet = &watch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= Q_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            Q_IDLE: begin
                if (want) begin
                    state_nx = Q_ASK;
                end
            end
            Q_ASK: begin
                if (!want) begin
                    state_nx = Q_IDLE;
                end else if (!grant_n && quiet) begin
                    state_nx = Q_OWN;
                end
            end
            Q_OWN: begin
                if (!want) begin
                    state_nx = Q_IDLE;
                end
            end
            default: state_nx = Q_IDLE;
        endcase
    end

    always_comb begin
        req_n  = 1'b1;
        gack_n = 1'b1;
        owns   = 1'b0;
        unique case (state)
            Q_IDLE: ;
            Q_ASK:  req_n = 1'b0;
            Q_OWN: begin
                gack_n = 1'b0;
                owns   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/arb_bus_handover.sv
module arb_bus_handover
    import arb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_want,
    input  logic as_n,
    input  logic dtack_n,
    input  logic ext_gack_n,
    output logic bus_req_n,
    output logic bus_grant_n,
    output logic bus_gack_n,
    output logic dma_owns,
    output logic master_release
);

    logic [W_BITS-1:0] watch_raw;
    logic [W_BITS-1:0] watch_q;

    always_comb begin
        watch_raw        = '1;
        watch_raw[W_AS]  = as_n;
        watch_raw[W_DTK] = dtack_n;
        watch_raw[W_EXT] = ext_gack_n;
    end

    arb_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (W_BITS),
        .IDLE   ({W_BITS{1'b1}})
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (watch_raw),
        .q     (watch_q)
    );

    arb_requester_fsm i_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .want    (dma_want),
        .grant_n (bus_grant_n),
        .watch_q (watch_q),
        .req_n   (bus_req_n),
        .gack_n  (bus_gack_n),
        .owns    (dma_owns)
    );

    arb_master_fsm i_mst (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_n     (bus_req_n),
        .gack_n    (bus_gack_n),
        .grant_n   (bus_grant_n),
        .release_o (master_release)
    );

endmodule

// File: rtl/arb_bus_handover_chk.sv
module arb_bus_handover_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_req_n,
    input logic bus_grant_n,
    input logic bus_gack_n,
    input logic master_release
);

    // R3: a new grant always follows a request sampled the cycle before
    a_r3_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_grant_n) |-> !$past(bus_req_n));

    // R4: acknowledge only rises while a grant was present
    a_r4_gack_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_gack_n) |-> !$past(bus_grant_n));

    // R5: the grant is negated once the acknowledge is seen
    a_r5_grant_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_gack_n && !bus_grant_n) |=> bus_grant_n);

    // R5: release only begins after an acknowledge
    a_r5_release_after_gack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(master_release) |-> !$past(bus_gack_n));

    // R6: master reclaims the bus one clock after acknowledge negates
    a_r6_reclaim: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_gack_n) && master_release) |=> !master_release);

    // R6: release is held while acknowledge stays asserted
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (master_release && !bus_gack_n) |=> master_release);

    // R7: a request dropped before acknowledge withdraws the grant
    a_r7_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_req_n) && !bus_grant_n && bus_gack_n) |=> (bus_grant_n && !master_release));

    // R8: never a grant outstanding while the bus is already handed over
    a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_grant_n && master_release));

endmodule

bind arb_bus_handover arb_bus_handover_chk i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_req_n      (bus_req_n),
    .bus_grant_n    (bus_grant_n),
    .bus_gack_n     (bus_gack_n),
    .master_release (master_release)
);

// File: tb/test_arb_bus_handover.sv
`timescale 1ns/1ps
module test_arb_bus_handover;

    localparam int L = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_want = 1'b0;
    logic as_n = 1'b1;
    logic dtack_n = 1'b1;
    logic ext_gack_n = 1'b1;
    logic bus_req_n, bus_grant_n, bus_gack_n, dma_owns, master_release;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    arb_bus_handover #(.SYNC_STAGES(L)) i_arb_bus_handover (
        .clk            (clk),
        .rst_n          (rst_n),
        .dma_want       (dma_want),
        .as_n           (as_n),
        .dtack_n        (dtack_n),
        .ext_gack_n     (ext_gack_n),
        .bus_req_n      (bus_req_n),
        .bus_grant_n    (bus_grant_n),
        .bus_gack_n     (bus_gack_n),
        .dma_owns       (dma_owns),
        .master_release (master_release)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle_checks(input string tag);
        chk({tag, " req_n"},   int'(bus_req_n), 1);
        chk({tag, " grant_n"}, int'(bus_grant_n), 1);
        chk({tag, " gack_n"},  int'(bus_gack_n), 1);
        chk({tag, " owns"},    int'(dma_owns), 0);
        chk({tag, " release"}, int'(master_release), 0);
    endtask

    // One handover with a, d, x busy clocks on as_n, dtack_n, ext_gack_n
    task automatic handover(input int a, input int d, input int x);
        int e;
        e = 3;
        if (a > 0 && a + 1 + L > e) e = a + 1 + L;
        if (d > 0 && d + 1 + L > e) e = d + 1 + L;
        if (x > 0 && x + 1 + L > e) e = x + 1 + L;
        @(negedge clk);
        dma_want   = 1'b1;
        as_n       = (a > 0) ? 1'b0 : 1'b1;
        dtack_n    = (d > 0) ? 1'b0 : 1'b1;
        ext_gack_n = (x > 0) ? 1'b0 : 1'b1;
        for (int n = 1; n <= e + 2; n++) begin
            @(negedge clk);
            chk($sformatf("R2 req_n a%0d d%0d x%0d n%0d", a, d, x, n),
                int'(bus_req_n), (n < e) ? 0 : 1);
            chk($sformatf("R3 grant_n a%0d d%0d x%0d n%0d", a, d, x, n),
                int'(bus_grant_n), (n >= 2 && n <= e) ? 0 : 1);
            chk($sformatf("R4 gack_n a%0d d%0d x%0d n%0d", a, d, x, n),
                int'(bus_gack_n), (n >= e) ? 0 : 1);
            chk($sformatf("R5 release a%0d d%0d x%0d n%0d", a, d, x, n),
                int'(master_release), (n >= e + 1) ? 1 : 0);
            chk($sformatf("R8 single a%0d d%0d x%0d n%0d", a, d, x, n),
                int'(!bus_grant_n && master_release), 0);
            if (n == a) as_n = 1'b1;
            if (n == d) dtack_n = 1'b1;
            if (n == x) ext_gack_n = 1'b1;
        end
        chk($sformatf("R9 owns a%0d d%0d x%0d", a, d, x), int'(dma_owns), 1);
        dma_want = 1'b0;
        @(negedge clk);
        chk($sformatf("R9 gack_n drop a%0d d%0d x%0d", a, d, x), int'(bus_gack_n), 1);
        chk($sformatf("R6 release held a%0d d%0d x%0d", a, d, x), int'(master_release), 1);
        @(negedge clk);
        chk($sformatf("R6 reclaim a%0d d%0d x%0d", a, d, x), int'(master_release), 0);
        @(negedge clk);
        idle_checks("R1 after handover");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_checks("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        idle_checks("R1 after reset");

        for (int a = 0; a < 4; a++) begin
            for (int d = 0; d < 4; d++) begin
                for (int x = 0; x < 4; x++) begin
                    handover(a, d, x);
                end
            end
        end

        // R7: request withdrawn while a long transfer holds the bus busy
        @(negedge clk);
        dma_want = 1'b1;
        as_n     = 1'b0;
        @(negedge clk);
        chk("R2 withdraw req", int'(bus_req_n), 0);
        @(negedge clk);
        chk("R3 withdraw grant", int'(bus_grant_n), 0);
        dma_want = 1'b0;
        @(negedge clk);
        chk("R7 req dropped", int'(bus_req_n), 1);
        chk("R7 grant still out", int'(bus_grant_n), 0);
        chk("R7 gack idle", int'(bus_gack_n), 1);
        @(negedge clk);
        chk("R7 grant withdrawn", int'(bus_grant_n), 1);
        chk("R7 release never", int'(master_release), 0);
        as_n = 1'b1;
        repeat (3) @(negedge clk);
        idle_checks("R7 idle");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #600000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule